// File: doc/BRIEF.md
# Audio Interface Interrupt and Frame-Match Unit

This block sits beside an audio serial interface. It keeps a free-running count of audio frames and compares it with a value that software programs. It also collects eight event sources into a single 32-bit control word. Each source owns a pair of bits: an enable bit and a pending bit. Seven of the sources arrive as one-cycle pulses from other parts of the audio interface. The eighth is generated inside the block, when the frame count arrives at the programmed match value.

Software reaches the block through a plain register port: an address, write data, a write strobe and combinational read data. A pending bit latches its event whether or not the source is enabled. Software clears a pending bit by writing 1 to it. A single level-sensitive interrupt request line is high while any source is both pending and enabled. The register port carries single-cycle accesses with no flow control, so it has no valid/ready handshake and never applies back-pressure.

Top module: `aiu_irq_frame_unit`

## Requirements
- R1: Register offsets are 0x00 for the control word, 0x40 for the frame count and 0x50 for the match value. Any other offset reads as zero. In the control word, source i (0 to 7) has its enable at bit 17+2i and its pending flag at bit 16+2i. Source 7 is the frame match. Sources 6 down to 0 are fed by `evt_i[6]` down to `evt_i[0]`. Bits 15:0 read as zero.
- R2: A 1 on `evt_i[i]` sets pending bit 16+2i at the next clock edge, whatever the state of the source's enable bit.
- R3: A write to the control word loads every enable bit from the write data. For each pending bit, a written 1 clears the bit and a written 0 leaves it unchanged.
- R4: When an event and a write-1-to-clear reach the same pending bit in the same cycle, the event wins and the bit stays set.
- R5: `irq_o` is high exactly when at least one source has both its pending bit and its enable bit set.
- R6: The frame count resets to 0, rises by one on each cycle in which `frame_tick_i` is high, and wraps from 0xFFFFFFFF to 0.
- R7: A write to offset 0x40 presets the frame count. If a tick arrives in the same cycle, the write takes priority.
- R8: A match event for source 7 happens only in the cycle in which the count becomes equal to the match value. No further event happens while the count stays equal. The pending bit (bit 30) is set at the following clock edge.
- R9: After reset, all enable bits, pending bits, the count and the match value are zero, `irq_o` is low, and the equality of count and match that holds at reset does not raise a match event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| frame_tick_i | input | 1 | One-cycle pulse for each audio frame |
| evt_i | input | 7 | One-cycle event pulses for sources 6..0 |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench sweeps each of the seven external sources with its enable both cleared and set. For each case it reads back the control word, which tells apart a wrong bit position, a latch that depends on the enable, and a fault in the interrupt gating. It then writes zeros and ones to the pending positions, which separates a true write-1-to-clear from a plain overwrite, and it drives an event and a clear together to show which one has priority. For the counter, the bench presets values just below the match and just below the wrap point. This shows whether the match fires exactly once, whether it stays quiet while the count holds, and whether a preset write takes priority over a simultaneous tick.

// File: rtl/aiu_pkg.sv
package aiu_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CNT_W     = 32;
  localparam int unsigned NUM_SRC   = 8;
  localparam int unsigned NUM_EXT   = NUM_SRC - 1;
  localparam int unsigned PAIR_BASE = 16;
  localparam int unsigned SRC_FRAME = NUM_SRC - 1;

  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 8'h50;

  function automatic int unsigned en_bit(int unsigned src);
    return PAIR_BASE + 2 * src + 1;
  endfunction

  function automatic int unsigned pd_bit(int unsigned src);
    return PAIR_BASE + 2 * src;
  endfunction
endpackage

// File: rtl/aiu_frame_counter.sv
module aiu_frame_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (load_i) begin
      count_o <= load_val_i;
    end else if (tick_i) begin
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/aiu_match_detect.sv
module aiu_match_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count_i,
  input  logic         match_we_i,
  input  logic [W-1:0] match_wdata_i,
  output logic [W-1:0] match_val_o,
  output logic         hit_o
);
  logic equal;
  logic equal_q;

  assign equal = (count_i == match_val_o);
  assign hit_o = equal & ~equal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_val_o <= '0;
      equal_q     <= 1'b1;
    end else begin
      if (match_we_i) match_val_o <= match_wdata_i;
      equal_q <= equal;
    end
  end
endmodule

// File: rtl/aiu_pending_bank.sv
module aiu_pending_bank
  import aiu_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  input  logic [N-1:0]      src_evt_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      pend_o,
  output logic              irq_o
);
  logic [N-1:0] wr_en;
  logic [N-1:0] wr_clr;

  for (genvar g = 0; g < N; g++) begin : g_pair
    assign wr_en[g]  = ctl_wdata_i[en_bit(g)];
    assign wr_clr[g] = ctl_wdata_i[pd_bit(g)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= '0;
      pend_o <= '0;
    end else begin
      if (ctl_we_i) en_o <= wr_en;
      for (int i = 0; i < N; i++) begin
        if (src_evt_i[i]) pend_o[i] <= 1'b1;
        else if (ctl_we_i && wr_clr[i]) pend_o[i] <= 1'b0;
      end
    end
  end

  assign irq_o = |(en_o & pend_o);
endmodule

// File: rtl/aiu_irq_frame_unit.sv
module aiu_irq_frame_unit
  import aiu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_tick_i,
  input  logic [NUM_EXT-1:0] evt_i,
  output logic              irq_o
);
  logic              ctl_we, cnt_we, match_we;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  match_val;
  logic              frame_hit;
  logic [NUM_SRC-1:0] src_evt;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] pend;
  logic [DATA_W-1:0] ctl_word;

  assign ctl_we   = reg_we_i && (reg_addr_i == OFS_CTL);
  assign cnt_we   = reg_we_i && (reg_addr_i == OFS_COUNT);
  assign match_we = reg_we_i && (reg_addr_i == OFS_MATCH);

  aiu_frame_counter #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_we), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .tick_i(frame_tick_i), .count_o(count)
  );

  aiu_match_detect #(.W(CNT_W)) i_match (
    .clk(clk), .rst_n(rst_n), .count_i(count), .match_we_i(match_we),
    .match_wdata_i(reg_wdata_i[CNT_W-1:0]), .match_val_o(match_val), .hit_o(frame_hit)
  );

  assign src_evt = {frame_hit, evt_i};

  aiu_pending_bank #(.N(NUM_SRC)) i_bank (
    .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(reg_wdata_i),
    .src_evt_i(src_evt), .en_o(en), .pend_o(pend), .irq_o(irq_o)
  );

  always_comb begin
    ctl_word = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      ctl_word[en_bit(i)] = en[i];
      ctl_word[pd_bit(i)] = pend[i];
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTL:   reg_rdata_o = ctl_word;
      OFS_COUNT: reg_rdata_o = DATA_W'(count);
      OFS_MATCH: reg_rdata_o = DATA_W'(match_val);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/aiu_irq_frame_checker.sv
module aiu_irq_frame_checker
  import aiu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               reg_we_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               frame_tick_i,
  input logic [NUM_EXT-1:0] evt_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend,
  input logic [CNT_W-1:0]   count,
  input logic               frame_hit
);
  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend[NUM_EXT-1:0] & $past(evt_i)) == $past(evt_i))); // R2
  AST_PEND_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_i && reg_addr_i == OFS_CTL) |=> ((pend & $past(pend)) == $past(pend))); // R3
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend != '0)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick_i && !(reg_we_i && reg_addr_i == OFS_COUNT)) |=> (count == CNT_W'($past(count) + 1'b1))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick_i && !(reg_we_i && reg_addr_i == OFS_COUNT)) |=> $stable(count)); // R7
  AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit |=> !frame_hit); // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == OFS_CTL) |-> (reg_rdata_o[15:0] == 16'h0)); // R1
endmodule

bind aiu_irq_frame_unit aiu_irq_frame_checker i_checker (
  .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
  .reg_rdata_o(reg_rdata_o), .frame_tick_i(frame_tick_i), .evt_i(evt_i),
  .irq_o(irq_o), .pend(pend), .count(count), .frame_hit(frame_hit)
);

// File: tb/test_aiu_irq_frame_unit.sv
module test_aiu_irq_frame_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        frame_tick = 1'b0;
  logic [6:0]  evt = 7'h0;
  logic        irq;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  aiu_irq_frame_unit i_aiu_irq_frame_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_we_i(reg_we), .reg_rdata_o(reg_rdata), .frame_tick_i(frame_tick),
    .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evt = 7'(1 << idx);
    @(negedge clk);
    evt = 7'h0;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R9 reset state, no spurious match event
    rd(8'h00, d); check("R9 ctl", d, 32'h0);
    rd(8'h40, d); check("R9 count", d, 32'h0);
    rd(8'h50, d); check("R9 match", d, 32'h0);
    check("R9 irq", {31'h0, irq}, 32'h0);

    // R2 R3 R5 R1 sweep every external source, enable off and on
    for (int s = 0; s < 7; s++) begin
      for (int e = 0; e < 2; e++) begin
        logic [31:0] enb, pdb;
        enb = e ? (32'h1 << (17 + 2 * s)) : 32'h0;
        pdb = 32'h1 << (16 + 2 * s);
        wr(8'h00, enb | 32'h5555_0000);
        pulse(s);
        rd(8'h00, d); check("R2 pending set", d, enb | pdb);
        check("R5 irq", {31'h0, irq}, {31'h0, e[0]});
        wr(8'h00, enb);
        rd(8'h00, d); check("R3 write 0 keeps pending", d, enb | pdb);
        wr(8'h00, enb | pdb);
        rd(8'h00, d); check("R3 write 1 clears", d, enb);
        check("R5 irq after clear", {31'h0, irq}, 32'h0);
      end
    end

    // R4 event wins over clear
    wr(8'h00, 32'h0000_0000);
    pulse(2);
    @(negedge clk);
    reg_addr = 8'h00; reg_wdata = 32'h0010_0000; reg_we = 1'b1; evt = 7'h04;
    @(negedge clk);
    reg_we = 1'b0; evt = 7'h0;
    rd(8'h00, d); check("R4 event beats clear", d, 32'h0010_0000);
    wr(8'h00, 32'h5555_0000);

    // R1 unmapped offset and low bits
    rd(8'h20, d); check("R1 unmapped reads zero", d, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R1 low bits zero", d, 32'hAAAA_0000);
    wr(8'h00, 32'h5555_0000);

    // R6 ticking and wrap
    wr(8'h50, 32'h0000_1000);
    wr(8'h40, 32'h0000_0005);
    for (int t = 0; t < 3; t++) tick();
    rd(8'h40, d); check("R6 count steps", d, 32'h8);
    wr(8'h40, 32'hFFFF_FFFF);
    tick();
    rd(8'h40, d); check("R6 wrap", d, 32'h0);

    // R7 write wins over tick
    @(negedge clk);
    reg_addr = 8'h40; reg_wdata = 32'h0000_0010; reg_we = 1'b1; frame_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; frame_tick = 1'b0;
    rd(8'h40, d); check("R7 preset priority", d, 32'h10);

    // R8 match sweep over several values
    for (int j = 0; j < 4; j++) begin
      m = 32'h0000_0100 + 32'(j * 37);
      wr(8'h50, m);
      wr(8'h40, m - 2);
      wr(8'h00, 32'h8000_0000);
      tick();
      rd(8'h00, d); check("R8 no event before match", d, 32'h8000_0000);
      tick();
      idle(1);
      rd(8'h00, d); check("R8 event at match", d, 32'hC000_0000);
      check("R5 irq on match", {31'h0, irq}, 32'h1);
      wr(8'h00, 32'hC000_0000);
      idle(5);
      rd(8'h00, d); check("R8 no refire while equal", d, 32'h8000_0000);
      rd(8'h40, d); check("R8 count at match", d, m);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule